// File: doc/BRIEF.md
# Mask-Compare Handshake Stream Router

This block steers a valid/ready stream to one of two destinations. Every transfer on the input carries a match word and a payload. The match word is compared against a mask fixed when the block is built, using a comparison mode also fixed at build time. When the comparison holds, the transfer goes to the selected destination. Otherwise it goes to the default destination. Backpressure follows the chosen path: the input is ready exactly when the destination that the current transfer is headed for is ready.

The comparison family covers five kinds of test. None never selects. Any-bit selects on at least one common set bit, and all-bits selects when every mask bit is present. Differ and not-equal select on any mismatching bit, and equal selects on an exact match. The four unsigned magnitude tests are greater, greater-or-equal, less and less-or-equal, each with the match word on the left of the operator. A build option adds a single-entry register stage. That stage captures the match word, the payload and the routing decision together and presents them one cycle later. A held entry can drain and be replaced in the same cycle. An unknown mode name, or a mask whose bit length differs from the width parameter, stops elaboration with an error.

Top module: `msr_router`

## Requirements
- R1: In mode "none" every valid transfer raises only the default valid (dflt_valid=1, sel_valid=0), whatever the match word.
- R2: In mode "or" a transfer is selected when (match & mask) is non-zero. With mask 4'b1101, match 4'b0100 is selected and 4'b0010 goes to default.
- R3: In mode "and" a transfer is selected only when (match & mask) equals mask. With mask 4'b1101, 4'b1101 is selected and 4'b1001 goes to default.
- R4: In modes "xor" and "not_equal" a transfer is selected when the match word differs from the mask in any bit.
- R5: In mode "equal" a transfer is selected only when the match word equals the mask exactly.
- R6: Modes "gt", "ge", "lt" and "le" select when match > mask, match >= mask, match < mask and match <= mask respectively, compared as unsigned numbers.
- R7: Without the register stage, while in_valid is 1 exactly one of dflt_valid/sel_valid is 1 (sel_valid when selected). While in_valid is 0, both are 0.
- R8: Without the register stage, in_ready equals sel_ready for a selected transfer and dflt_ready otherwise.
- R9: out_match and out_data carry the match word and payload of the transfer on the output unchanged.
- R10: With the register stage, a transfer accepted at a clock edge (in_valid and in_ready both 1) appears on its destination valid right after that edge, with its match word and payload.
- R11: With the register stage, a held entry whose destination ready is 0 keeps its valid, destination, match word and payload stable. While an entry is held, in_ready equals that entry's destination ready.
- R12: With the register stage, when the held entry drains in the same cycle a new transfer arrives, in_ready is 1 and the new transfer is held after that edge. A drain with no new input leaves both valids 0.
- R13: A synchronous active-high rst clears the register stage: after a reset edge both output valids are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input transfer present |
| in_ready | output | 1 | Input transfer can be taken |
| in_match | input | WIDTH | Word compared against the mask |
| in_data | input | PAY_W | Payload carried unchanged |
| dflt_valid | output | 1 | Transfer offered on the default destination |
| dflt_ready | input | 1 | Default destination can take a transfer |
| sel_valid | output | 1 | Transfer offered on the selected destination |
| sel_ready | input | 1 | Selected destination can take a transfer |
| out_match | output | WIDTH | Match word of the offered transfer |
| out_data | output | PAY_W | Payload of the offered transfer |

## Verification
With the register stage, the held entry can drain to its destination on the same edge that a new transfer is taken into the freed slot. The bench provokes this in two ways. It parks an entry bound for the selected destination, then raises sel_ready while a default-bound transfer waits at the input. It also streams three alternating transfers with both readies high. In each cycle in_ready must be 1, and after the edge the new transfer's destination, match word and payload must be on the outputs with no empty cycle between them. The opposite case is also checked: ready on the wrong destination must not drain the entry.

// File: rtl/msr_pkg.sv
package msr_pkg;

   // comparison kinds; CMP_BAD marks a name that was not recognised
   typedef enum logic [3:0] {
      CMP_NONE,
      CMP_ANY,
      CMP_ALL,
      CMP_DIFF,
      CMP_EQ,
      CMP_NE,
      CMP_GT,
      CMP_GE,
      CMP_LT,
      CMP_LE,
      CMP_BAD
   } cmp_mode_e;

   function automatic cmp_mode_e mode_from_name(input string name);
      if (name == "none")      return CMP_NONE;
      if (name == "or")        return CMP_ANY;
      if (name == "and")       return CMP_ALL;
      if (name == "xor")       return CMP_DIFF;
      if (name == "equal")     return CMP_EQ;
      if (name == "not_equal") return CMP_NE;
      if (name == "gt")        return CMP_GT;
      if (name == "ge")        return CMP_GE;
      if (name == "lt")        return CMP_LT;
      if (name == "le")        return CMP_LE;
      return CMP_BAD;
   endfunction

endpackage

// File: rtl/msr_compare.sv
module msr_compare #(
   parameter int                    WIDTH  = 4,
   parameter logic [WIDTH-1:0]      MASK_V = '0,
   parameter msr_pkg::cmp_mode_e    MODE_E = msr_pkg::CMP_NONE
) (
   input  logic [WIDTH-1:0] match_word,
   output logic             hit
);

   // one comparator is built, chosen by the mode
   generate
      case (MODE_E)
         msr_pkg::CMP_ANY: begin : g_any
            assign hit = |(match_word & MASK_V);
         end
         msr_pkg::CMP_ALL: begin : g_all
            assign hit = ((match_word & MASK_V) == MASK_V);
         end
         msr_pkg::CMP_DIFF: begin : g_diff
            assign hit = |(match_word ^ MASK_V);
         end
         msr_pkg::CMP_EQ: begin : g_eq
            assign hit = (match_word == MASK_V);
         end
         msr_pkg::CMP_NE: begin : g_ne
            assign hit = (match_word != MASK_V);
         end
         msr_pkg::CMP_GT: begin : g_gt
            assign hit = (match_word > MASK_V);
         end
         msr_pkg::CMP_GE: begin : g_ge
            assign hit = (match_word >= MASK_V);
         end
         msr_pkg::CMP_LT: begin : g_lt
            assign hit = (match_word < MASK_V);
         end
         msr_pkg::CMP_LE: begin : g_le
            assign hit = (match_word <= MASK_V);
         end
         default: begin : g_never
            logic unused_word;
            assign unused_word = ^match_word;
            assign hit = 1'b0;
         end
      endcase
   endgenerate

endmodule

// File: rtl/msr_route.sv
module msr_route (
   input  logic valid_in,
   input  logic hit,
   input  logic dflt_rdy,
   input  logic sel_rdy,
   output logic dflt_vld,
   output logic sel_vld,
   output logic path_rdy
);

   always_comb begin
      dflt_vld = valid_in & ~hit;
      sel_vld  = valid_in & hit;
      path_rdy = hit ? sel_rdy : dflt_rdy;
   end

endmodule

// File: rtl/msr_hold_stage.sv
module msr_hold_stage #(
   parameter int WIDTH = 4,
   parameter int PAY_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             take,
   input  logic             drain,
   input  logic             hit_in,
   input  logic [WIDTH-1:0] match_in,
   input  logic [PAY_W-1:0] data_in,
   output logic             full,
   output logic             hit_q,
   output logic [WIDTH-1:0] match_q,
   output logic [PAY_W-1:0] data_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         full <= 1'b0;
      end else if (take) begin
         full <= 1'b1;
      end else if (drain) begin
         full <= 1'b0;
      end
   end

   // decision and contents are captured together
   always_ff @(posedge clk) begin
      if (rst) begin
         hit_q   <= 1'b0;
         match_q <= '0;
         data_q  <= '0;
      end else if (take) begin
         hit_q   <= hit_in;
         match_q <= match_in;
         data_q  <= data_in;
      end
   end

endmodule

// File: rtl/msr_router.sv
module msr_router #(
   parameter int    WIDTH      = 4,
   parameter        MASK       = 4'b1101,
   parameter string MODE       = "ge",
   parameter int    PAY_W      = 8,
   parameter bit    REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_match,
   input  logic [PAY_W-1:0] in_data,
   output logic             dflt_valid,
   input  logic             dflt_ready,
   output logic             sel_valid,
   input  logic             sel_ready,
   output logic [WIDTH-1:0] out_match,
   output logic [PAY_W-1:0] out_data
);

   localparam msr_pkg::cmp_mode_e MODE_E = msr_pkg::mode_from_name(MODE);
   localparam int                 MASK_BITS = $bits(MASK);
   localparam logic [WIDTH-1:0]   MASK_V = WIDTH'(MASK);

   // elaboration checks
   generate
      if (MODE_E == msr_pkg::CMP_BAD) begin : g_bad_mode
         $error("msr_router: unknown comparison mode name");
      end
      if (MASK_BITS != WIDTH) begin : g_bad_mask
         $error("msr_router: mask length differs from WIDTH");
      end
      if (WIDTH < 1 || PAY_W < 1) begin : g_bad_width
         $error("msr_router: WIDTH and PAY_W must be positive");
      end
   endgenerate

   logic in_hit;

   msr_compare #(
      .WIDTH  (WIDTH),
      .MASK_V (MASK_V),
      .MODE_E (MODE_E)
   ) cmp_i (
      .match_word (in_match),
      .hit        (in_hit)
   );

   generate
      if (REGISTERED) begin : g_reg
         logic             full;
         logic             hit_q;
         logic             held_rdy;
         logic             take;
         logic             drain;

         msr_route route_i (
            .valid_in (full),
            .hit      (hit_q),
            .dflt_rdy (dflt_ready),
            .sel_rdy  (sel_ready),
            .dflt_vld (dflt_valid),
            .sel_vld  (sel_valid),
            .path_rdy (held_rdy)
         );

         assign drain    = full & held_rdy;
         assign in_ready = ~full | held_rdy;
         assign take     = in_valid & in_ready;

         msr_hold_stage #(
            .WIDTH (WIDTH),
            .PAY_W (PAY_W)
         ) hold_i (
            .clk      (clk),
            .rst      (rst),
            .take     (take),
            .drain    (drain),
            .hit_in   (in_hit),
            .match_in (in_match),
            .data_in  (in_data),
            .full     (full),
            .hit_q    (hit_q),
            .match_q  (out_match),
            .data_q   (out_data)
         );
      end else begin : g_comb
         logic unused_clocking;
         assign unused_clocking = clk ^ rst;

         msr_route route_i (
            .valid_in (in_valid),
            .hit      (in_hit),
            .dflt_rdy (dflt_ready),
            .sel_rdy  (sel_ready),
            .dflt_vld (dflt_valid),
            .sel_vld  (sel_valid),
            .path_rdy (in_ready)
         );

         assign out_match = in_match;
         assign out_data  = in_data;
      end
   endgenerate

endmodule

// File: rtl/msr_router_chk.sv
module msr_router_chk #(
   parameter int WIDTH      = 4,
   parameter int PAY_W      = 8,
   parameter bit REGISTERED = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_ready,
   input logic [WIDTH-1:0] in_match,
   input logic [PAY_W-1:0] in_data,
   input logic             dflt_valid,
   input logic             dflt_ready,
   input logic             sel_valid,
   input logic             sel_ready,
   input logic [WIDTH-1:0] out_match,
   input logic [PAY_W-1:0] out_data
);

   // R7
   one_route_chk: assert property (@(posedge clk) disable iff (rst)
      !(dflt_valid && sel_valid));

   // R8
   ready_dflt_chk: assert property (@(posedge clk) disable iff (rst)
      dflt_valid |-> (in_ready == dflt_ready));

   // R8
   ready_sel_chk: assert property (@(posedge clk) disable iff (rst)
      sel_valid |-> (in_ready == sel_ready));

   generate
      if (REGISTERED) begin : g_reg_chk
         logic was_rst;
         always_ff @(posedge clk) was_rst <= rst;

         // R13
         rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
            was_rst |-> (!dflt_valid && !sel_valid));

         // R11
         dflt_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (dflt_valid && !dflt_ready && !was_rst) |=>
               (dflt_valid && $stable(out_match) && $stable(out_data)));

         // R11
         sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (sel_valid && !sel_ready && !was_rst) |=>
               (sel_valid && $stable(out_match) && $stable(out_data)));

         // R10
         capture_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_ready) |=>
               ((dflt_valid || sel_valid) && out_data == $past(in_data)
                && out_match == $past(in_match)));
      end else begin : g_comb_chk
         // R7
         idle_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |-> (!dflt_valid && !sel_valid));

         // R9
         pass_chk: assert property (@(posedge clk) disable iff (rst)
            (out_match == in_match) && (out_data == in_data));
      end
   endgenerate

endmodule

bind msr_router msr_router_chk #(
   .WIDTH      (WIDTH),
   .PAY_W      (PAY_W),
   .REGISTERED (REGISTERED)
) chk_i (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .in_match   (in_match),
   .in_data    (in_data),
   .dflt_valid (dflt_valid),
   .dflt_ready (dflt_ready),
   .sel_valid  (sel_valid),
   .sel_ready  (sel_ready),
   .out_match  (out_match),
   .out_data   (out_data)
);

// File: tb/msr_router_tb.sv
module msr_router_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NMODES     = 10;
   localparam logic [3:0] MASK = 4'b1101;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;

   function automatic string mode_name(input int i);
      case (i)
         0: return "none";
         1: return "or";
         2: return "and";
         3: return "xor";
         4: return "equal";
         5: return "not_equal";
         6: return "gt";
         7: return "ge";
         8: return "lt";
         default: return "le";
      endcase
   endfunction

   function automatic string req_of(input int i);
      case (i)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3, 5: return "R4";
         4: return "R5";
         default: return "R6";
      endcase
   endfunction

   function automatic bit exp_hit(input int i, input logic [3:0] m);
      case (i)
         0: return 1'b0;
         1: return (m & MASK) != 4'b0000;
         2: return (m & MASK) == MASK;
         3, 5: return m != MASK;
         4: return m == MASK;
         6: return m > MASK;
         7: return m >= MASK;
         8: return m < MASK;
         default: return m <= MASK;
      endcase
   endfunction

   // combinational instances, one per mode
   logic       c_valid = 1'b0;
   logic [3:0] c_match = '0;
   logic [7:0] c_data  = '0;
   logic       c_dready = 1'b0;
   logic       c_sready = 1'b0;
   logic [NMODES-1:0] c_dv, c_sv, c_rdy;
   logic [3:0] c_om [NMODES];
   logic [7:0] c_od [NMODES];

   for (genvar g = 0; g < NMODES; g++) begin : cmb_g
      msr_router #(
         .WIDTH (4), .MASK (4'b1101), .MODE (mode_name(g)),
         .PAY_W (8), .REGISTERED (1'b0)
      ) cmb_i (
         .clk (clk), .rst (rst),
         .in_valid (c_valid), .in_ready (c_rdy[g]),
         .in_match (c_match), .in_data (c_data),
         .dflt_valid (c_dv[g]), .dflt_ready (c_dready),
         .sel_valid (c_sv[g]), .sel_ready (c_sready),
         .out_match (c_om[g]), .out_data (c_od[g])
      );
   end

   // registered instance, mode ge
   logic       r_valid = 1'b0;
   logic [3:0] r_match = '0;
   logic [7:0] r_data  = '0;
   logic       r_dready = 1'b0;
   logic       r_sready = 1'b0;
   logic       r_rdy, r_dv, r_sv;
   logic [3:0] r_om;
   logic [7:0] r_od;

   msr_router #(
      .WIDTH (4), .MASK (4'b1101), .MODE ("ge"),
      .PAY_W (8), .REGISTERED (1'b1)
   ) dut_i (
      .clk (clk), .rst (rst),
      .in_valid (r_valid), .in_ready (r_rdy),
      .in_match (r_match), .in_data (r_data),
      .dflt_valid (r_dv), .dflt_ready (r_dready),
      .sel_valid (r_sv), .sel_ready (r_sready),
      .out_match (r_om), .out_data (r_od)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic next_cycle();
      @(posedge clk);
      @(negedge clk);
   endtask

   // drive at the falling edge, sample one time unit later
   task automatic drive_r(input logic v, input logic [3:0] m, input logic [7:0] d,
                          input logic dr, input logic sr);
      r_valid = v; r_match = m; r_data = d; r_dready = dr; r_sready = sr;
      #1;
   endtask

   task automatic t_comb_sweep();
      for (int m = 0; m < 16; m++) begin
         for (int rd = 0; rd < 4; rd++) begin
            c_valid = 1'b1; c_match = 4'(m); c_data = {4'(m), ~4'(m)};
            c_dready = rd[0]; c_sready = rd[1];
            #1;
            for (int i = 0; i < NMODES; i++) begin
               automatic bit e = exp_hit(i, 4'(m));
               check(req_of(i), {mode_name(i), " sel_valid"}, 32'(c_sv[i]), 32'(e));
               check("R7", {mode_name(i), " dflt_valid"}, 32'(c_dv[i]), 32'(!e));
               check("R8", {mode_name(i), " in_ready"}, 32'(c_rdy[i]),
                     32'(e ? rd[1] : rd[0]));
               check("R9", {mode_name(i), " out_match"}, 32'(c_om[i]), 32'(m));
               check("R9", {mode_name(i), " out_data"}, 32'(c_od[i]),
                     32'({4'(m), ~4'(m)}));
            end
            @(negedge clk);
         end
      end
   endtask

   task automatic t_comb_idle();
      for (int m = 0; m < 16; m += 5) begin
         c_valid = 1'b0; c_match = 4'(m); c_dready = 1'b1; c_sready = 1'b1;
         #1;
         check("R7", "idle valids", 32'({c_dv, c_sv}), 32'd0);
         @(negedge clk);
      end
   endtask

   task automatic t_reset_state();
      check("R13", "reset dflt_valid", 32'(r_dv), 32'd0);
      check("R13", "reset sel_valid", 32'(r_sv), 32'd0);
      check("R13", "reset in_ready", 32'(r_rdy), 32'd1);
   endtask

   task automatic t_capture_hold();
      drive_r(1'b1, 4'b1110, 8'hA5, 1'b0, 1'b0);
      check("R10", "empty in_ready", 32'(r_rdy), 32'd1);
      @(posedge clk); @(negedge clk);
      drive_r(1'b0, 4'b0000, 8'h00, 1'b0, 1'b0);
      check("R10", "sel_valid after capture", 32'(r_sv), 32'd1);
      check("R10", "dflt_valid after capture", 32'(r_dv), 32'd0);
      check("R10", "match after capture", 32'(r_om), 32'hE);
      check("R10", "data after capture", 32'(r_od), 32'hA5);
      check("R11", "held in_ready", 32'(r_rdy), 32'd0);
      // ready on the other destination must not drain the entry
      drive_r(1'b0, 4'b0000, 8'h00, 1'b1, 1'b0);
      check("R11", "in_ready ignores dflt_ready", 32'(r_rdy), 32'd0);
      for (int k = 0; k < 3; k++) begin
         next_cycle(); #1;
         check("R11", "held sel_valid", 32'(r_sv), 32'd1);
         check("R11", "held data", 32'(r_od), 32'hA5);
         check("R11", "held match", 32'(r_om), 32'hE);
      end
   endtask

   task automatic t_drain_fill();
      // entry 1110 still held for sel; drain it while a default one arrives
      drive_r(1'b1, 4'b0101, 8'h3C, 1'b0, 1'b1);
      check("R12", "in_ready on drain", 32'(r_rdy), 32'd1);
      @(posedge clk); @(negedge clk);
      drive_r(1'b0, 4'b0000, 8'h00, 1'b0, 1'b0);
      check("R12", "dflt_valid refilled", 32'(r_dv), 32'd1);
      check("R12", "sel_valid after drain", 32'(r_sv), 32'd0);
      check("R12", "refill data", 32'(r_od), 32'h3C);
      check("R12", "refill match", 32'(r_om), 32'h5);
      drive_r(1'b0, 4'b0000, 8'h00, 1'b1, 1'b0);
      @(posedge clk); @(negedge clk); #1;
      check("R12", "empty after drain", 32'({r_dv, r_sv}), 32'd0);
      check("R12", "in_ready after drain", 32'(r_rdy), 32'd1);
   endtask

   task automatic t_stream();
      drive_r(1'b1, 4'b1101, 8'h11, 1'b1, 1'b1);
      @(posedge clk); @(negedge clk);
      drive_r(1'b1, 4'b0000, 8'h22, 1'b1, 1'b1);
      check("R10", "stream 1 sel", 32'({r_dv, r_sv}), 32'b01);
      check("R10", "stream 1 data", 32'(r_od), 32'h11);
      check("R12", "stream 1 in_ready", 32'(r_rdy), 32'd1);
      @(posedge clk); @(negedge clk);
      drive_r(1'b1, 4'b1111, 8'h33, 1'b1, 1'b1);
      check("R10", "stream 2 dflt", 32'({r_dv, r_sv}), 32'b10);
      check("R10", "stream 2 data", 32'(r_od), 32'h22);
      check("R12", "stream 2 in_ready", 32'(r_rdy), 32'd1);
      @(posedge clk); @(negedge clk);
      drive_r(1'b0, 4'b0000, 8'h00, 1'b1, 1'b1);
      check("R10", "stream 3 sel", 32'({r_dv, r_sv}), 32'b01);
      check("R10", "stream 3 data", 32'(r_od), 32'h33);
      @(posedge clk); @(negedge clk); #1;
      check("R12", "stream drained", 32'({r_dv, r_sv}), 32'd0);
   endtask

   task automatic t_reset_mid();
      drive_r(1'b1, 4'b0001, 8'h44, 1'b0, 1'b0);
      @(posedge clk); @(negedge clk);
      drive_r(1'b0, 4'b0000, 8'h00, 1'b0, 1'b0);
      check("R10", "held before reset", 32'(r_dv), 32'd1);
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      rst = 1'b0;
      #1;
      t_reset_state();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements) act=timeout exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      t_reset_state();
      @(negedge clk);
      t_comb_idle();
      t_comb_sweep();
      t_capture_hold();
      t_drain_fill();
      @(negedge clk);
      t_stream();
      @(negedge clk);
      t_reset_mid();
      @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule